// File: doc/BRIEF.md
# Nonvolatile Write Protection Sequencer

This block sits between a bus master and a byte-writable memory split into two planes, selected by address bit 12. It watches every bus write for unlock command sequences at fixed offsets inside a plane. It keeps a global write-protect flag and an 8-bit block lockout mask that covers eight 1 KB blocks. Writes that pass both checks are collected into a page buffer. When the page timeout expires, the buffer is committed through a timed programming cycle.

While a plane is programming, reads of that plane return a toggling status bit. Reads of the other plane return stored data. The sequencer also produces one-cycle load strobes for the block mask and for two address-map registers held elsewhere. All timeouts are counted in clock cycles. The memory is a behavioural array. Each 1 KB block keeps 2^CELL_AW cells, indexed by address bits 12:10 and the low CELL_AW bits.

Top module: `nv_wguard`

## Requirements
- R1: After reset, glob_prot is 1, blk_mask is 00h, busy is 0 and rdata is 00h.
- R2: While glob_prot is 1, a write that is not preceded by the unlock sequence stores nothing and starts no programming cycle.
- R3: The three writes AAh@555h, 55h@AAAh, A0h@555h enable the data writes that follow them. The offsets are address bits 11:0. After programming, those writes read back the written bytes.
- R4: A write that does not match the next expected command step returns the recogniser to idle. After that, the write that would have completed the unlock has no effect.
- R5: The extended sequence AAh@555h, 55h@AAAh, 80h@555h, AAh@555h, 55h@AAAh, then 20h@555h clears glob_prot and leaves blk_mask unchanged. Plain writes are then accepted.
- R6: An extended sequence ending in C0h makes the next write, to any address, load its data byte into blk_mask, with a one-cycle mask_ld pulse. Bit i locks the block at addr[12:10]==i against all writes, unlocked or not.
- R7: Final codes D0h and E0h make the next write pulse rmap_ld or mmap_ld, with ld_data equal to that write's data. Any register load sets glob_prot to 1.
- R8: A page holds at most 32 bytes, all in the plane of its first byte. Further writes into a full page are dropped.
- R9: busy rises PAGE_TO cycles after the last accepted write. It stays high for PROG_CYC cycles. eow then pulses high for exactly one cycle as busy falls.
- R10: If wr_hold is 1 while a page is pending, the page is discarded and memory keeps its old contents.
- R11: During programming, each read of the busy plane returns 00h or 40h, with bit 6 alternating and starting at 0. Reads of the other plane return stored data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Bus write this cycle |
| rd_en | input | 1 | Bus read this cycle; rdata is valid on the next cycle |
| addr | input | 13 | Byte address; bit 12 selects the plane |
| wdata | input | 8 | Write data |
| wr_hold | input | 1 | High cancels a pending page |
| rdata | output | 8 | Registered read data or toggle status |
| busy | output | 1 | Programming cycle in progress |
| eow | output | 1 | One-cycle end-of-write pulse |
| glob_prot | output | 1 | Global write protection active |
| blk_mask | output | 8 | Block lockout mask |
| mask_ld | output | 1 | Block mask load strobe |
| rmap_ld | output | 1 | Register-map load strobe |
| mmap_ld | output | 1 | Memory-map load strobe |
| ld_data | output | 8 | Data for the map register loads |

## Verification
A recogniser left in the wrong step shows up within one programming window. Either a protected write starts busy, or an unlocked write fails to start it. The effect is visible PAGE_TO cycles after the write. A wrong page count or a wrong lock bit appears only on read-back after eow, as a byte that is stale or overwritten. The bench therefore pre-loads every location it expects to stay untouched. A broken toggle bit is exposed by two back-to-back reads of the busy plane.

// File: rtl/nv_wguard.sv
module nv_wguard #(
  parameter int PAGE_TO  = 16,
  parameter int PROG_CYC = 40,
  parameter int PAGE_MAX = 32,
  parameter int CELL_AW  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [12:0] addr,
  input  logic [7:0]  wdata,
  input  logic        wr_hold,
  output logic [7:0]  rdata,
  output logic        busy,
  output logic        eow,
  output logic        glob_prot,
  output logic [7:0]  blk_mask,
  output logic        mask_ld,
  output logic        rmap_ld,
  output logic        mmap_ld,
  output logic [7:0]  ld_data
);
  localparam int IDX_W = 3 + CELL_AW;
  localparam int TW    = $clog2(PAGE_TO + 1);
  localparam int PW    = $clog2(PROG_CYC + 1);
  localparam int PC_W  = $clog2(PAGE_MAX + 1);

  logic [2:0]       seq;
  logic             armed;
  logic [1:0]       tgt;
  logic [TW-1:0]    tmr;
  logic [PW-1:0]    pcyc;
  logic [PC_W-1:0]  pcnt;
  logic             pl, prog_pl, tog;
  logic [IDX_W-1:0] pidx [PAGE_MAX];
  logic [7:0]       pdat [PAGE_MAX];
  logic [7:0]       mem  [2**IDX_W];
  logic             step_ok;

  wire [IDX_W-1:0] idx = {addr[12:10], addr[CELL_AW-1:0]};
  wire a555     = addr[11:0] == 12'h555;
  wire aAAA     = addr[11:0] == 12'hAAA;
  wire active   = seq != 3'd0 || armed || tgt != 2'd0 || pcnt != '0;
  wire expire   = !busy && active && tmr == TW'(PAGE_TO - 1);
  wire cancel   = !busy && wr_hold && (pcnt != '0 || armed);
  wire take     = !busy && !cancel && !expire && wr_en;
  wire cmd_mode = !armed && pcnt == '0 && tgt == 2'd0;
  wire data_ok  = (!glob_prot || armed) && !blk_mask[addr[12:10]] &&
                  pcnt < PC_W'(PAGE_MAX) && (pcnt == '0 || addr[12] == pl);
  wire store    = take && tgt == 2'd0 && !(cmd_mode && (step_ok || seq != 3'd0)) && data_ok;
  wire commit   = busy && pcyc == PW'(PROG_CYC - 1);

  always_comb begin
    case (seq)
      3'd0, 3'd3: step_ok = a555 && wdata == 8'hAA;
      3'd1, 3'd4: step_ok = aAAA && wdata == 8'h55;
      3'd2:       step_ok = a555 && (wdata == 8'hA0 || wdata == 8'h80);
      3'd5:       step_ok = a555 && (wdata == 8'hC0 || wdata == 8'hD0 ||
                                     wdata == 8'hE0 || wdata == 8'h20);
      default:    step_ok = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (store) begin
      pidx[pcnt] <= idx;
      pdat[pcnt] <= wdata;
    end
    if (commit)
      for (int i = 0; i < PAGE_MAX; i++)
        if (PC_W'(i) < pcnt) mem[pidx[i]] <= pdat[i];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seq <= '0; armed <= 1'b0; tgt <= '0; tmr <= '0; pcyc <= '0; pcnt <= '0;
      pl <= 1'b0; prog_pl <= 1'b0; tog <= 1'b0; busy <= 1'b0; eow <= 1'b0;
      glob_prot <= 1'b1; blk_mask <= '0; mask_ld <= 1'b0; rmap_ld <= 1'b0;
      mmap_ld <= 1'b0; ld_data <= '0; rdata <= '0;
    end else begin
      eow <= 1'b0; mask_ld <= 1'b0; rmap_ld <= 1'b0; mmap_ld <= 1'b0;
      if (rd_en) begin
        if (busy && addr[12] == prog_pl) begin
          rdata <= {1'b0, tog, 6'b0};
          tog   <= ~tog;
        end else rdata <= mem[idx];
      end
      if (busy) begin
        pcyc <= pcyc + 1'b1;
        if (commit) begin
          busy <= 1'b0; eow <= 1'b1; pcnt <= '0;
        end
      end else if (cancel) begin
        pcnt <= '0; armed <= 1'b0; seq <= '0; tgt <= '0; tmr <= '0;
      end else if (expire) begin
        seq <= '0; armed <= 1'b0; tgt <= '0; tmr <= '0;
        if (pcnt != '0) begin
          busy <= 1'b1; prog_pl <= pl; pcyc <= '0; tog <= 1'b0;
        end
      end else if (take) begin
        tmr <= '0;
        if (tgt != 2'd0) begin
          glob_prot <= 1'b1;
          tgt       <= '0;
          ld_data   <= wdata;
          case (tgt)
            2'd1:    begin blk_mask <= wdata; mask_ld <= 1'b1; end
            2'd2:    rmap_ld <= 1'b1;
            default: mmap_ld <= 1'b1;
          endcase
        end else if (cmd_mode && step_ok) begin
          if (seq == 3'd2 && wdata == 8'hA0) begin
            armed <= 1'b1; seq <= '0;
          end else if (seq == 3'd5) begin
            seq <= '0;
            case (wdata)
              8'hC0:   tgt <= 2'd1;
              8'hD0:   tgt <= 2'd2;
              8'hE0:   tgt <= 2'd3;
              default: glob_prot <= 1'b0;
            endcase
          end else seq <= seq + 3'd1;
        end else if (cmd_mode && seq != 3'd0) begin
          seq <= '0;
        end else if (store) begin
          if (pcnt == '0) pl <= addr[12];
          pcnt <= pcnt + 1'b1;
        end
      end else if (active) begin
        tmr <= tmr + 1'b1;
      end
    end
  end

  p_eow_end_r9: assert property (@(posedge clk) disable iff (!rst_n)
    eow |-> !busy && $past(busy));
  p_load_sets_prot_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_ld || rmap_ld || mmap_ld) |-> glob_prot);
  p_one_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mask_ld, rmap_ld, mmap_ld}));
  p_mask_only_on_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_ld |-> $stable(blk_mask));
  p_page_cap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt <= PC_W'(PAGE_MAX));
endmodule

// File: tb/nv_wguard_tb.sv
module nv_wguard_tb;
  localparam int PAGE_TO  = 16;
  localparam int PROG_CYC = 40;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, wr_hold = 1'b0;
  logic [12:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata, blk_mask, ld_data;
  logic        busy, eow, glob_prot, mask_ld, rmap_ld, mmap_ld;
  int checks = 0, errors = 0, cyc = 0;
  logic [7:0] rv;

  localparam logic [20:0] TBL [5] = '{
    {13'h0001, 8'hA1}, {13'h0402, 8'hB2}, {13'h0803, 8'hC3},
    {13'h0C04, 8'hD4}, {13'h0830, 8'hEE}};

  nv_wguard u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .wr_hold(wr_hold), .rdata(rdata), .busy(busy),
    .eow(eow), .glob_prot(glob_prot), .blk_mask(blk_mask), .mask_ld(mask_ld),
    .rmap_ld(rmap_ld), .mmap_ld(mmap_ld), .ld_data(ld_data));

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 100000) begin
      errors = errors + 1;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [12:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [12:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic unlock();
    wr(13'h555, 8'hAA); wr(13'hAAA, 8'h55); wr(13'h555, 8'hA0);
  endtask

  task automatic ext(input logic [7:0] code);
    wr(13'h555, 8'hAA); wr(13'hAAA, 8'h55); wr(13'h555, 8'h80);
    wr(13'h555, 8'hAA); wr(13'hAAA, 8'h55); wr(13'h555, code);
  endtask

  task automatic finish_prog(input string tag);
    int pulses = 0;
    for (int i = 0; i < PAGE_TO + PROG_CYC + 10; i++) begin
      @(negedge clk);
      if (eow) pulses++;
    end
    chk(tag, {31'd0, busy}, 32'd0);
    chk(tag, pulses, 32'd1);
  endtask

  task automatic idle_check(input string tag);
    repeat (PAGE_TO + 6) @(negedge clk);
    chk(tag, {31'd0, busy}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 glob_prot", {31'd0, glob_prot}, 32'd1);
    chk("R1 blk_mask", {24'd0, blk_mask}, 32'd0);
    chk("R1 busy", {31'd0, busy}, 32'd0);
    chk("R1 rdata", {24'd0, rdata}, 32'd0);

    wr(13'h0100, 8'h11);
    idle_check("R2 protected write started no cycle");

    unlock();
    wr(13'h1010, 8'h5A);
    repeat (PAGE_TO - 2) @(negedge clk);
    chk("R9 busy before timeout", {31'd0, busy}, 32'd0);
    repeat (2) @(negedge clk);
    chk("R9 busy after timeout", {31'd0, busy}, 32'd1);
    repeat (PROG_CYC - 4) @(negedge clk);
    chk("R9 busy held", {31'd0, busy}, 32'd1);
    finish_prog("R9 end of write");
    rd(13'h1010, rv);
    chk("R3 unlocked byte stored", {24'd0, rv}, 32'h5A);

    wr(13'h555, 8'hAA); wr(13'hAAA, 8'h55); wr(13'h555, 8'h00);
    wr(13'h555, 8'hA0); wr(13'h0020, 8'h77);
    idle_check("R4 broken sequence left write locked");

    ext(8'h20);
    @(negedge clk);
    chk("R5 glob_prot cleared", {31'd0, glob_prot}, 32'd0);
    chk("R5 blk_mask kept", {24'd0, blk_mask}, 32'd0);

    for (int i = 0; i < 5; i++) wr(TBL[i][20:8], TBL[i][7:0]);
    repeat (PAGE_TO + 2) @(negedge clk);
    chk("R5 plain page started", {31'd0, busy}, 32'd1);
    rd(13'h0001, rv); chk("R11 first busy read", {24'd0, rv}, 32'h00);
    rd(13'h0002, rv); chk("R11 second busy read", {24'd0, rv}, 32'h40);
    rd(13'h1010, rv); chk("R11 other plane read", {24'd0, rv}, 32'h5A);
    rd(13'h0003, rv); chk("R11 third busy read", {24'd0, rv}, 32'h00);
    finish_prog("R9 table page");
    for (int i = 0; i < 5; i++) begin
      rd(TBL[i][20:8], rv);
      chk("R5 table readback", {24'd0, rv}, {24'd0, TBL[i][7:0]});
    end

    for (int i = 0; i < 33; i++) wr(13'h0810 + 13'(i), 8'(i + 1));
    finish_prog("R8 full page");
    rd(13'h082F, rv); chk("R8 byte 32 stored", {24'd0, rv}, 32'h20);
    rd(13'h0830, rv); chk("R8 byte 33 dropped", {24'd0, rv}, 32'hEE);

    ext(8'hC0);
    wr(13'h1FFF, 8'h02);
    chk("R6 mask_ld pulse", {31'd0, mask_ld}, 32'd1);
    chk("R6 blk_mask loaded", {24'd0, blk_mask}, 32'h02);
    chk("R7 glob_prot set by load", {31'd0, glob_prot}, 32'd1);
    unlock();
    wr(13'h0405, 8'h99);
    idle_check("R6 locked block ignored");
    unlock();
    wr(13'h0402, 8'h99);
    idle_check("R6 locked block ignored again");
    rd(13'h0402, rv); chk("R6 locked byte kept", {24'd0, rv}, 32'hB2);

    ext(8'h20);
    @(negedge clk);
    chk("R5 cleared again", {31'd0, glob_prot}, 32'd0);
    ext(8'hD0);
    wr(13'h0007, 8'h3C);
    chk("R7 rmap_ld", {31'd0, rmap_ld}, 32'd1);
    chk("R7 ld_data", {24'd0, ld_data}, 32'h3C);
    chk("R7 glob_prot", {31'd0, glob_prot}, 32'd1);
    chk("R7 mask kept", {24'd0, blk_mask}, 32'h02);
    ext(8'hE0);
    wr(13'h1234, 8'h5C);
    chk("R7 mmap_ld", {31'd0, mmap_ld}, 32'd1);
    chk("R7 ld_data e", {24'd0, ld_data}, 32'h5C);

    unlock();
    wr(13'h0001, 8'h44);
    @(negedge clk); wr_hold = 1'b1;
    @(negedge clk); wr_hold = 1'b0;
    idle_check("R10 cancelled page no cycle");
    rd(13'h0001, rv); chk("R10 old data kept", {24'd0, rv}, 32'hA1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule